// File: doc/BRIEF.md
# Multi-Mode Bipolar Line Encoder

This block turns a serial binary bit stream into two unipolar return-to-zero mark lines. One line carries the positive pulses of a ternary line code and the other carries the negative pulses. Circuitry outside the block combines the two lines into the signal that drives the transmission line. A two-bit mode input selects plain alternate mark inversion or one of three zero-substitution codes: eight-zero, six-zero and high-density bipolar order 3. The substitution codes replace long runs of zeros with patterns that hold bipolar violations, so the line keeps enough pulse density for timing recovery.

Input bits are sampled on the falling clock edge. Each bit passes through a look-ahead window whose length matches the substitution group of the selected code. The window is the full group length because a run can only be recognised once all of it has arrived. The resulting symbol is launched on a rising edge and is present only while the clock is high. Two overrides act at the output. An idle control forces both lines low. An alarm control, obeyed only while the idle control is inactive, drives both lines with a pulse in every clock-high phase. The mode may only change while reset is held.

In the codes below, a V pulse has the same polarity as the pulse before it, and a B pulse has the opposite polarity. Every pulse the block emits, including substitution pulses, becomes the "pulse before" for the next mark.

Top module: `bipolar_line_encoder`

## Requirements
- R1: A bit sampled on falling edge k is emitted during the clock-high phase that follows falling edge k+N. N is 1 for mode 00, 8 for mode 01, 6 for mode 10 and 4 for mode 11.
- R2: Both outputs are low whenever the clock is low, so every mark is a return-to-zero pulse that lasts one clock-high phase.
- R3: Mode 00 (alternate mark inversion) sends a zero as no pulse on either line. It sends each one as a pulse whose polarity is opposite to the previous pulse. pos_out carries positive pulses and neg_out carries negative pulses.
- R4: Mode 01 replaces each complete group of eight zeros, counted from the last pulse or the end of the last group, with 0 0 0 V B 0 V B in time order.
- R5: Mode 10 replaces each complete group of six zeros with 0 V B 0 V B in time order.
- R6: Mode 11 replaces each complete group of four zeros with 0 0 0 V when the count of pulses sent since the last substitution is odd, and with B 0 0 V when that count is even. The count restarts at zero after each substitution. In every substituting mode, no more than N-1 zeros are emitted back to back.
- R7: When oe_n is high at a rising edge, both outputs stay low for the clock-high phase that edge starts. Encoding carries on underneath without change.
- R8: When force_ais is high and oe_n is low at a rising edge, both outputs pulse high during the clock-high phase that edge starts.
- R9: Reset is synchronous and active low. It clears the window, clears both outputs and clears the pulse count, and it sets the previous pulse polarity to negative. The first N+1 rising edges after reset emit nothing.
- R10: pos_out and neg_out are never high in the same phase unless the alarm override is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock: data is sampled on the falling edge and marks are launched on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Code select: 00 alternate mark inversion, 01 eight-zero substitution, 10 six-zero substitution, 11 high-density order 3 |
| nrz_in | input | 1 | Serial binary data in |
| oe_n | input | 1 | High forces both outputs low |
| force_ais | input | 1 | High, with oe_n low, drives both outputs with all ones |
| pos_out | output | 1 | Positive mark line, return-to-zero |
| neg_out | output | 1 | Negative mark line, return-to-zero |

## Verification
The assertions assume that the mode is held steady outside reset and that reset starts low at time zero. On that basis, the zero-run and alternation checks may trust the mode as the code being sent. They also assume the override inputs change only away from the rising edge. The bench applies a reset before every mode and drives all inputs two nanoseconds after a rising edge. It then feeds each mode the whole sequence of 8-bit values from 0 to 255, followed by a long zero tail. Meanwhile it pulses the idle and alarm overrides on two co-prime cycle periods, so the overrides meet every kind of symbol, sometimes together.

// File: rtl/lcode_pkg.sv
// Shared types and code tables for the bipolar line encoder.
// Assumes: mode values and group lengths are fixed by the line codes themselves.
package lcode_pkg;

    localparam int WIN_MAX = 8;

    typedef enum logic [1:0] {
        MODE_AMI  = 2'b00,
        MODE_B8   = 2'b01,
        MODE_B6   = 2'b10,
        MODE_HDB3 = 2'b11
    } lc_mode_e;

    // Symbol tokens held in the look-ahead window.
    typedef enum logic [2:0] {
        TK_EMPTY = 3'd0,
        TK_ZERO  = 3'd1,
        TK_MARK  = 3'd2,
        TK_BIP   = 3'd3,
        TK_VIOL  = 3'd4
    } lc_tok_e;

    // Window length (and latency) for each code.
    function automatic int win_len(input lc_mode_e m);
        case (m)
            MODE_B8:   return 8;
            MODE_B6:   return 6;
            MODE_HDB3: return 4;
            default:   return 1;
        endcase
    endfunction

    // Token at time position t (0 = earliest) of a substitution group.
    function automatic lc_tok_e sub_tok(input lc_mode_e m, input int t, input logic even);
        lc_tok_e r;
        r = TK_ZERO;
        case (m)
            MODE_B8: begin
                if (t == 3 || t == 6)      r = TK_VIOL;
                else if (t == 4 || t == 7) r = TK_BIP;
            end
            MODE_B6: begin
                if (t == 1 || t == 4)      r = TK_VIOL;
                else if (t == 2 || t == 5) r = TK_BIP;
            end
            MODE_HDB3: begin
                if (t == 3)                r = TK_VIOL;
                else if (t == 0 && even)   r = TK_BIP;
            end
            default: r = TK_ZERO;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcode_window.sv
// Look-ahead token window. Shifts one token in per falling edge and presents
// the token at the active depth as the head. When the newest group of
// window-length slots holds only real zeros, it rewrites them with the
// substitution tokens of the selected code.
// Assumes: mode is held steady outside reset; par_even reflects the pulse
// count after the head consumed on this same edge.
module lcode_window
    import lcode_pkg::*;
#(
    parameter int SLOTS = WIN_MAX
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lc_mode_e mode,
    input  logic     nrz,
    input  logic     par_even,
    output lc_tok_e  head
);

    lc_tok_e win [SLOTS];
    lc_tok_e nxt [SLOTS];
    int      depth;
    logic    run_full;

    // Active window depth for the selected code.
    always_comb depth = win_len(mode);

    // Select the oldest active slot as the head token.
    always_comb begin
        head = TK_EMPTY;
        for (int i = 0; i < SLOTS; i++) begin
            if (i == depth - 1) head = win[i];
        end
    end

    // Detect a complete zero group formed by the incoming bit and the newest slots.
    always_comb begin
        run_full = (mode != MODE_AMI) && !nrz;
        for (int i = 0; i < SLOTS - 1; i++) begin
            if ((i + 2 <= depth) && (win[i] != TK_ZERO)) run_full = 1'b0;
        end
    end

    // Build the next window: plain shift, or shift with substitution overlay.
    always_comb begin
        nxt[0] = nrz ? TK_MARK : TK_ZERO;
        for (int i = 1; i < SLOTS; i++) nxt[i] = win[i-1];
        if (run_full) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (i < depth) nxt[i] = sub_tok(mode, depth - 1 - i, par_even);
            end
        end
    end

    // Window storage, advanced on the sampling (falling) edge.
    always_ff @(negedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (!rst_n) win[i] <= TK_EMPTY;
            else        win[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/lcode_polarity.sv
// Polarity assignment. Turns the head token into a signed mark. A normal mark
// or B pulse takes the opposite of the previous polarity; a V pulse repeats it.
// Keeps the odd/even pulse count used by the four-zero code, which restarts
// on every substitution violation.
// Assumes: head is stable between falling edges.
module lcode_polarity
    import lcode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lc_mode_e mode,
    input  lc_tok_e  head,
    output logic     emit_pos,
    output logic     emit_neg,
    output logic     par_even
);

    logic last_pos;
    logic par_odd;
    logic is_mark;
    logic pol_pos;
    logic par_nxt;

    // Decide whether the head is a pulse and which polarity it takes.
    always_comb begin
        is_mark = (head == TK_MARK) || (head == TK_BIP) || (head == TK_VIOL);
        pol_pos = (head == TK_VIOL) ? last_pos : !last_pos;
    end

    // Next pulse-count parity; a four-zero-code violation closes the count.
    always_comb begin
        if (head == TK_VIOL && mode == MODE_HDB3) par_nxt = 1'b0;
        else if (is_mark)                         par_nxt = !par_odd;
        else                                      par_nxt = par_odd;
        par_even = !par_nxt;
    end

    // Register the emitted symbol and the running state.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            emit_pos <= 1'b0;
            emit_neg <= 1'b0;
            last_pos <= 1'b0;
            par_odd  <= 1'b0;
        end else begin
            emit_pos <= is_mark && pol_pos;
            emit_neg <= is_mark && !pol_pos;
            if (is_mark) last_pos <= pol_pos;
            par_odd  <= par_nxt;
        end
    end

endmodule

// File: rtl/lcode_lane.sv
// One output lane. Launches its symbol on the rising edge with the idle and
// alarm overrides applied, and gates it with the clock-high phase so the line
// returns to zero.
// Assumes: override inputs are stable around the rising edge.
module lcode_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic force_ais,
    input  logic sym,
    output logic q,
    output logic line
);

    // Launch register with idle taking priority over alarm.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (oe_n)      q <= 1'b0;
        else if (force_ais) q <= 1'b1;
        else                q <= sym;
    end

    // Return-to-zero shaping.
    assign line = q & clk;

endmodule

// File: rtl/bipolar_line_encoder.sv
// Multi-mode bipolar line encoder top. Serial binary in; positive and negative
// return-to-zero mark lines out. Window, polarity tracker and two output lanes.
// Assumes: mode changes only while rst_n is low.
module bipolar_line_encoder
    import lcode_pkg::*;
#(
    parameter int WIN_SLOTS = WIN_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       nrz_in,
    input  logic       oe_n,
    input  logic       force_ais,
    output logic       pos_out,
    output logic       neg_out
);

    localparam int LANES = 2;

    lc_mode_e         mode_e;
    lc_tok_e          head_tok;
    logic             par_even;
    logic             emit_pos;
    logic             emit_neg;
    logic [LANES-1:0] lane_sym;
    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] lane_line;

    assign mode_e = lc_mode_e'(mode);

    lcode_window #(.SLOTS(WIN_SLOTS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .nrz      (nrz_in),
        .par_even (par_even),
        .head     (head_tok)
    );

    lcode_polarity u_polarity (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .head     (head_tok),
        .emit_pos (emit_pos),
        .emit_neg (emit_neg),
        .par_even (par_even)
    );

    assign lane_sym = {emit_neg, emit_pos};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lcode_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .oe_n      (oe_n),
            .force_ais (force_ais),
            .sym       (lane_sym[g]),
            .q         (lane_q[g]),
            .line      (lane_line[g])
        );
    end

    assign pos_out = lane_line[0];
    assign neg_out = lane_line[1];

endmodule

// File: rtl/bipolar_line_encoder_chk.sv
// Checker for the bipolar line encoder, bound to the top. Tracks its own copy
// of the last emitted polarity and the current zero run.
// Assumes: rst_n is low at time zero and mode is steady outside reset.
module bipolar_line_encoder_chk
    import lcode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       oe_n,
    input logic       force_ais,
    input lc_tok_e    head_tok,
    input logic       emit_pos,
    input logic       emit_neg,
    input logic [1:0] lane_q
);

    lc_mode_e   mode_e;
    logic       seen_pos;
    logic [3:0] zrun;
    logic [3:0] zlim;

    assign mode_e = lc_mode_e'(mode);
    always_comb zlim = 4'(win_len(mode_e));

    // Remember the polarity of the most recent emitted pulse.
    always_ff @(negedge clk) begin
        if (!rst_n)                    seen_pos <= 1'b0;
        else if (emit_pos || emit_neg) seen_pos <= emit_pos;
    end

    // Count consecutive zero symbols leaving the window.
    always_ff @(negedge clk) begin
        if (!rst_n)                                         zrun <= 4'd0;
        else if (head_tok == TK_ZERO && zrun != 4'hF)       zrun <= zrun + 4'd1;
        else if (head_tok != TK_ZERO && head_tok != TK_EMPTY) zrun <= 4'd0;
    end

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n) |-> (lane_q == 2'b00));

    assert_ais_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(oe_n) && $past(force_ais)) |-> (lane_q == 2'b11));

    assert_single_polarity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(force_ais) |-> (lane_q != 2'b11));

    assert_ami_alternate_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (mode_e == MODE_AMI && (emit_pos || emit_neg)) |-> (emit_pos != seen_pos));

    assert_zero_run_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (mode_e != MODE_AMI) |-> (zrun < zlim));

endmodule

bind bipolar_line_encoder bipolar_line_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .oe_n      (oe_n),
    .force_ais (force_ais),
    .head_tok  (head_tok),
    .emit_pos  (emit_pos),
    .emit_neg  (emit_neg),
    .lane_q    (lane_q)
);

// File: tb/tb_bipolar_line_encoder.sv
module tb_bipolar_line_encoder;

    localparam int LT = 2100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic nrz_in = 1'b0;
    logic oe_n = 1'b0;
    logic force_ais = 1'b0;
    logic pos_out;
    logic neg_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit bitv [LT];
    int tok  [LT];
    bit ep   [LT];
    bit en   [LT];

    always #10 clk = ~clk;

    bipolar_line_encoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .nrz_in    (nrz_in),
        .oe_n      (oe_n),
        .force_ais (force_ais),
        .pos_out   (pos_out),
        .neg_out   (neg_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wlen(input int m);
        case (m)
            1: return 8;
            2: return 6;
            3: return 4;
            default: return 1;
        endcase
    endfunction

    // Substitution token at time position t: 0 zero, 2 B, 3 V (R4, R5, R6).
    function automatic int sub_tb(input int m, input int t, input bit odd);
        if (m == 1) begin
            if (t == 3 || t == 6) return 3;
            if (t == 4 || t == 7) return 2;
        end else if (m == 2) begin
            if (t == 1 || t == 4) return 3;
            if (t == 2 || t == 5) return 2;
        end else if (m == 3) begin
            if (t == 3) return 3;
            if (t == 0 && !odd) return 2;
        end
        return 0;
    endfunction

    function automatic bit oe_at(input int c);
        return (c % 53) >= 49;
    endfunction

    function automatic bit fa_at(input int c);
        return (c % 31) >= 28;
    endfunction

    // Expected symbol stream for mode m computed from the code rules.
    task automatic build(input int m);
        int n;
        int z;
        bit odd;
        bit last;
        bit pol;
        n = wlen(m);
        z = 0;
        odd = 0;
        for (int j = 0; j < LT; j++) begin
            if (j < 2048) bitv[j] = ((j / 8) >> (7 - (j % 8))) & 1;
            else          bitv[j] = 0;
            if (bitv[j]) begin
                tok[j] = 1;
                z = 0;
                odd = !odd;
            end else begin
                tok[j] = 0;
                z++;
                if (m != 0 && z == n) begin
                    for (int t = 0; t < n; t++) tok[j - n + 1 + t] = sub_tb(m, t, odd);
                    z = 0;
                    if (m == 3) odd = 0;
                end
            end
        end
        last = 0;
        for (int j = 0; j < LT; j++) begin
            ep[j] = 0;
            en[j] = 0;
            if (tok[j] != 0) begin
                pol = (tok[j] == 3) ? last : !last;
                ep[j] = pol;
                en[j] = !pol;
                last = pol;
            end
        end
    endtask

    task automatic run_mode(input int m);
        int n;
        int idx;
        int exp;
        string tag;
        bit use_chk;
        n = wlen(m);
        build(m);
        @(posedge clk);
        #2;
        rst_n = 0;
        mode = 2'(m);
        nrz_in = 0;
        oe_n = 0;
        force_ais = 0;
        repeat (3) begin
            @(posedge clk);
            #5;
            chk("R9 reset state", {30'd0, pos_out, neg_out}, 0);
        end
        for (int c = 0; c < LT; c++) begin
            @(posedge clk);
            #2;
            rst_n = 1;
            nrz_in = bitv[c];
            oe_n = oe_at(c);
            force_ais = fa_at(c);
            #3;
            use_chk = 1;
            idx = c - n - 1;
            if (c == 0) begin
                exp = 0; tag = "R9 reset edge";
            end else if (oe_at(c - 1)) begin
                exp = 0; tag = "R7 idle override";
            end else if (fa_at(c - 1)) begin
                exp = 3; tag = "R8 alarm override";
            end else if (idx < 0) begin
                exp = 0; tag = "R9 R1 empty window";
            end else if (idx <= LT - 9) begin
                exp = {30'd0, ep[idx], en[idx]};
                case (m)
                    0: tag = "R1 R3 ami";
                    1: tag = "R1 R4 eight-zero";
                    2: tag = "R1 R5 six-zero";
                    default: tag = "R1 R6 four-zero";
                endcase
                if (idx < 16) tag = {tag, " R9"};
            end else begin
                use_chk = 0;
                exp = 0;
            end
            if (use_chk) chk(tag, {30'd0, pos_out, neg_out}, exp);
            if (!(c > 0 && fa_at(c - 1) && !oe_at(c - 1)))
                chk("R10 both lines", int'(pos_out & neg_out), 0);
            #10;
            chk("R2 low phase", {30'd0, pos_out, neg_out}, 0);
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++) run_mode(m);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule